// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the sequence of column addresses for a single read or write burst to a double-data-rate memory. A command is presented as a start pulse together with a start column, a length code (2, 4 or 8 beats), an ordering bit and a read flag. From the next cycle on, the block shows one column address per clock, with a valid flag and a flag on the final beat.

The beats stay inside the naturally aligned group of the burst length that holds the start column. The low bits cycle through the group either by wrapping addition (sequential order) or by XOR with the beat number (interleaved order). The bits above the group never change. A new command can follow the final beat with no gap.

For reads, the block also produces a read-data-valid strobe, one per beat, delayed by a programmed latency. The latency is given in half-clock units, so it can hold both the whole-cycle and the half-cycle settings. A side flag marks strobes whose data lands half a cycle later than the edge. An illegal latency code on a read is reported and suppresses the strobes of that burst.

Top module: `burst_col_seq`

## Requirements
- R1: A start is accepted when the block is idle or shows its final beat, and the length code is 0, 1 or 2 (2, 4 or 8 beats). From the cycle after the accepting edge, `col_vld_o` is high for exactly that many consecutive cycles, one beat per cycle.
- R2: `last_o` is high only on beat number length−1 of a burst, and it is high there.
- R3: With `itlv_i` = 0 (sequential), the low log2(length) bits of beat k are (start low bits + k) modulo the length. For example, length 4 from 1 gives 1,2,3,0.
- R4: With `itlv_i` = 1 (interleaved), the low log2(length) bits of beat k are start low bits XOR k. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R5: Column bits at and above position log2(length) equal those of the start column on every beat.
- R6: A start pulse during a beat that is not the final one is ignored. The running burst continues unchanged.
- R7: Length code 3 is reserved. A start carrying it is ignored and produces no beats.
- R8: `lat_i` gives the read latency in half cycles. Code 4 means 2 cycles and code 5 means 2.5 cycles. For a read accepted at edge n, `rd_vld_o` is high in the cycle after edge n+2+k for each beat k. `rd_half_o` is high with it exactly when the code is 5.
- R9: Latency codes other than 4 and 5 are reserved. For a read started with one, `lat_err_o` is high from the cycle after acceptance until the next accepted start, and that burst gives no `rd_vld_o`.
- R10: A write (`rd_i` = 0) gives no `rd_vld_o` and leaves `lat_err_o` low, whatever `lat_i` holds.
- R11: During reset, `col_vld_o`, `last_o`, `rd_vld_o`, `rd_half_o` and `lat_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst command pulse |
| start_col_i | input | COL_W | Start column address |
| blen_i | input | 2 | Length code: 0=2, 1=4, 2=8, 3 reserved |
| itlv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| rd_i | input | 1 | 1 for read, 0 for write |
| lat_i | input | LAT_W | Read latency in half cycles |
| col_o | output | COL_W | Column address of the current beat |
| col_vld_o | output | 1 | Beat valid |
| last_o | output | 1 | Final beat of the burst |
| rd_vld_o | output | 1 | Read data valid strobe after latency |
| rd_half_o | output | 1 | Strobe carries an extra half-cycle offset |
| lat_err_o | output | 1 | Reserved latency code seen on last read start |

## Verification
The bench builds the block with its defaults: a 10-bit column, a 3-bit latency field and a legal range of 4 to 5 half cycles. The wide column lets the bench check that the upper bits stay fixed while the low bits wrap. The 3-bit latency field makes the reserved codes below and above the legal range reachable. Every start offset is driven for every length and both orders. Commands are also held high across running bursts, which exercises the ignored starts, gapless chaining and strobes from consecutive bursts that abut.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int BEAT_W = 3;

    typedef enum logic [1:0] {
        BLEN_2   = 2'd0,
        BLEN_4   = 2'd1,
        BLEN_8   = 2'd2,
        BLEN_RSV = 2'd3
    } blen_e;

    typedef struct packed {
        logic vld;
        logic half;
    } rd_ent_t;

    // Mask of the in-group address bits for a burst of 2**len_log beats.
    function automatic logic [BEAT_W-1:0] grp_mask(input logic [1:0] len_log);
        return (BEAT_W'(1) << len_log) - BEAT_W'(1);
    endfunction

endpackage

// File: rtl/bcs_order.sv
module bcs_order
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic [1:0]        len_log_i,
    input  logic              itlv_i,
    output logic [COL_W-1:0]  col_o
);

    logic [BEAT_W-1:0] mask;
    logic [BEAT_W-1:0] lo;
    logic [BEAT_W-1:0] off;

    always_comb begin
        mask = grp_mask(len_log_i);
        lo   = base_i[BEAT_W-1:0];
        off  = itlv_i ? (lo ^ beat_i) : (lo + beat_i);
    end

    assign col_o[COL_W-1:BEAT_W] = base_i[COL_W-1:BEAT_W];

    for (genvar g = 0; g < BEAT_W; g++) begin : g_bit
        assign col_o[g] = mask[g] ? off[g] : lo[g];
    end

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int LAT_W     = 3,
    parameter int LAT_MIN_H = 4,
    parameter int LAT_MAX_H = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [1:0]        blen_i,
    input  logic              itlv_i,
    input  logic              rd_i,
    input  logic [LAT_W-1:0]  lat_i,
    output logic              active_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic [1:0]        len_log_o,
    output logic [COL_W-1:0]  base_o,
    output logic              itlv_o,
    output logic              last_o,
    output logic              push_o,
    output logic [LAT_W-1:0]  lat_o,
    output logic              lat_err_o
);

    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        logic [1:0]        len_log;
        logic [COL_W-1:0]  base;
        logic              itlv;
        logic              rd;
        logic [LAT_W-1:0]  lat;
        logic              err;
    } st_t;

    st_t  st_d, st_q;
    logic accept;
    logic lat_ok;
    logic is_last;

    always_comb begin
        st_d    = st_q;
        is_last = st_q.active && (st_q.beat == grp_mask(st_q.len_log));
        lat_ok  = (lat_i >= LAT_W'(LAT_MIN_H)) && (lat_i <= LAT_W'(LAT_MAX_H));
        accept  = start_i && (blen_i != BLEN_RSV) && (!st_q.active || is_last);

        if (accept) begin
            st_d.active  = 1'b1;
            st_d.beat    = '0;
            st_d.len_log = blen_i + 2'd1;
            st_d.base    = start_col_i;
            st_d.itlv    = itlv_i;
            st_d.rd      = rd_i;
            st_d.lat     = lat_i;
            st_d.err     = rd_i && !lat_ok;
        end else if (st_q.active) begin
            if (is_last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + BEAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o  = st_q.active;
    assign beat_o    = st_q.beat;
    assign len_log_o = st_q.len_log;
    assign base_o    = st_q.base;
    assign itlv_o    = st_q.itlv;
    assign last_o    = is_last;
    assign push_o    = st_q.active && st_q.rd && !st_q.err;
    assign lat_o     = st_q.lat;
    assign lat_err_o = st_q.err;

    AST_MID_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !last_o) |=> (active_o && beat_o == $past(beat_o) + BEAT_W'(1))); // R6

    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !active_o); // R2

    AST_RSV_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && start_i && blen_i == BLEN_RSV) |=> !active_o); // R7

    AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !rd_i && blen_i != BLEN_RSV && (!active_o || last_o)) |=> !lat_err_o); // R10

endmodule

// File: rtl/bcs_rdpipe.sv
module bcs_rdpipe
    import bcs_pkg::*;
#(
    parameter int LAT_W     = 3,
    parameter int LAT_MIN_H = 4,
    parameter int LAT_MAX_H = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             rd_vld_o,
    output logic             rd_half_o
);

    // Stages needed for the largest whole-cycle part of the latency.
    localparam int N = LAT_MAX_H / 2;

    typedef struct packed {
        rd_ent_t [N-1:0] ent;
    } pst_t;

    pst_t st_d, st_q;
    int   slot;

    // A strobe enters at the stage from which it needs exactly the
    // whole-cycle part of the latency to reach the output stage.
    always_comb begin
        slot      = N - int'(lat_i >> 1);
        st_d.ent[0] = '0;
        for (int i = 1; i < N; i++) begin
            st_d.ent[i] = st_q.ent[i-1];
        end
        for (int i = 0; i < N; i++) begin
            if (push_i && slot == i) begin
                st_d.ent[i].vld  = 1'b1;
                st_d.ent[i].half = lat_i[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld_o  = st_q.ent[N-1].vld;
    assign rd_half_o = st_q.ent[N-1].half;

    AST_PUSH_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (lat_i >= LAT_W'(LAT_MIN_H) && lat_i <= LAT_W'(LAT_MAX_H))); // R9

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W     = 10,
    parameter int LAT_W     = 3,
    parameter int LAT_MIN_H = 4,
    parameter int LAT_MAX_H = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       blen_i,
    input  logic             itlv_i,
    input  logic             rd_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_vld_o,
    output logic             last_o,
    output logic             rd_vld_o,
    output logic             rd_half_o,
    output logic             lat_err_o
);

    logic              active;
    logic [BEAT_W-1:0] beat;
    logic [1:0]        len_log;
    logic [COL_W-1:0]  base;
    logic              itlv;
    logic              push;
    logic [LAT_W-1:0]  lat;

    bcs_ctrl #(
        .COL_W     (COL_W),
        .LAT_W     (LAT_W),
        .LAT_MIN_H (LAT_MIN_H),
        .LAT_MAX_H (LAT_MAX_H)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_i      (blen_i),
        .itlv_i      (itlv_i),
        .rd_i        (rd_i),
        .lat_i       (lat_i),
        .active_o    (active),
        .beat_o      (beat),
        .len_log_o   (len_log),
        .base_o      (base),
        .itlv_o      (itlv),
        .last_o      (last_o),
        .push_o      (push),
        .lat_o       (lat),
        .lat_err_o   (lat_err_o)
    );

    bcs_order #(
        .COL_W (COL_W)
    ) order_i (
        .base_i    (base),
        .beat_i    (beat),
        .len_log_i (len_log),
        .itlv_i    (itlv),
        .col_o     (col_o)
    );

    bcs_rdpipe #(
        .LAT_W     (LAT_W),
        .LAT_MIN_H (LAT_MIN_H),
        .LAT_MAX_H (LAT_MAX_H)
    ) rdpipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .lat_i     (lat),
        .rd_vld_o  (rd_vld_o),
        .rd_half_o (rd_half_o)
    );

    assign col_vld_o = active;

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        col_vld_o |-> (col_o[COL_W-1:BEAT_W] == base[COL_W-1:BEAT_W])); // R5

endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 10;
    localparam int LAT_W      = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [COL_W-1:0] start_col_i;
    logic [1:0]       blen_i;
    logic             itlv_i;
    logic             rd_i;
    logic [LAT_W-1:0] lat_i;
    logic [COL_W-1:0] col_o;
    logic             col_vld_o;
    logic             last_o;
    logic             rd_vld_o;
    logic             rd_half_o;
    logic             lat_err_o;

    burst_col_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_i      (blen_i),
        .itlv_i      (itlv_i),
        .rd_i        (rd_i),
        .lat_i       (lat_i),
        .col_o       (col_o),
        .col_vld_o   (col_vld_o),
        .last_o      (last_o),
        .rd_vld_o    (rd_vld_o),
        .rd_half_o   (rd_half_o),
        .lat_err_o   (lat_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    chk_on = 1'b0;
    bit    done   = 1'b0;
    string tag    = "R1";

    // Reference model state
    int ex_col[$];
    bit ex_last[$];
    bit ex_itlv[$];
    int ex_len[$];
    int rdv[int];
    int rdh[int];
    bit ex_err = 1'b0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", t, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Model update at each edge, from the inputs only.
    always @(posedge clk) begin
        if (!rst_n) begin
            ex_col.delete(); ex_last.delete(); ex_itlv.delete(); ex_len.delete();
            ex_err = 1'b0;
        end else begin
            bit can_take;
            can_take = (ex_col.size() <= 1);
            if (ex_col.size() > 0) begin
                void'(ex_col.pop_front()); void'(ex_last.pop_front());
                void'(ex_itlv.pop_front()); void'(ex_len.pop_front());
            end
            cyc++;
            if (start_i && blen_i != 2'd3 && can_take) begin
                int len, s, hi;
                bit legal;
                len   = 2 << blen_i;
                s     = int'(start_col_i) % len;
                hi    = int'(start_col_i) - s;
                legal = (lat_i == 3'd4) || (lat_i == 3'd5);
                for (int k = 0; k < len; k++) begin
                    int off;
                    off = itlv_i ? (s ^ k) : ((s + k) % len);
                    ex_col.push_back(hi + off);
                    ex_last.push_back(k == len - 1);
                    ex_itlv.push_back(itlv_i);
                    ex_len.push_back(len);
                    if (rd_i && legal) begin
                        rdv[cyc + 2 + k] = 1;
                        rdh[cyc + 2 + k] = (lat_i == 3'd5) ? 1 : 0;
                    end
                end
                ex_err = rd_i && !legal;
            end
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            bit ev, eh;
            string rtag, etag;
            rtag = (tag == "R9" || tag == "R10") ? tag : "R8";
            etag = (tag == "R10") ? "R10" : "R9";
            chk(col_vld_o == (ex_col.size() > 0), tag, col_vld_o, ex_col.size() > 0);
            if (ex_col.size() > 0) begin
                int mask;
                mask = ex_len[0] - 1;
                chk(int'(col_o) == ex_col[0], ex_itlv[0] ? "R4" : "R3", col_o, ex_col[0]);
                chk((int'(col_o) & ~mask) == (ex_col[0] & ~mask), "R5",
                    int'(col_o) & ~mask, ex_col[0] & ~mask);
                chk(last_o == ex_last[0], "R2", last_o, ex_last[0]);
            end else begin
                chk(last_o == 1'b0, "R2", last_o, 0);
            end
            ev = rdv.exists(cyc);
            eh = ev ? (rdh[cyc] != 0) : 1'b0;
            chk(rd_vld_o == ev, rtag, rd_vld_o, ev);
            chk(rd_half_o == eh, "R8", rd_half_o, eh);
            chk(lat_err_o == ex_err, etag, lat_err_o, ex_err);
            if (ev) begin
                rdv.delete(cyc);
                rdh.delete(cyc);
            end
        end
    end

    task automatic issue(input int lc, input bit md, input int col, input bit rd, input int lat);
        @(negedge clk);
        start_i     = 1'b1;
        blen_i      = 2'(lc);
        itlv_i      = md;
        start_col_i = COL_W'(col);
        rd_i        = rd;
        lat_i       = LAT_W'(lat);
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; blen_i = '0;
        itlv_i = 1'b0; rd_i = 1'b0; lat_i = '0;
        repeat (3) @(negedge clk);
        // R11: quiet outputs in reset
        chk(col_vld_o == 1'b0, "R11", col_vld_o, 0);
        chk(last_o    == 1'b0, "R11", last_o, 0);
        chk(rd_vld_o  == 1'b0, "R11", rd_vld_o, 0);
        chk(rd_half_o == 1'b0, "R11", rd_half_o, 0);
        chk(lat_err_o == 1'b0, "R11", lat_err_o, 0);
        rst_n  = 1'b1;
        chk_on = 1'b1;

        // R1 R3 R4 R5 R8: every start offset, length and order
        tag = "R1";
        for (int lc = 0; lc < 3; lc++)
            for (int md = 0; md < 2; md++)
                for (int s = 0; s < 8; s++)
                    issue(lc, md[0], s | ((((lc * 7 + md * 3 + s) * 37) % 128) << 3),
                          (s % 3) != 0, 4 + (s % 2));

        // R6: start held high, fields changing every cycle
        tag = "R6";
        @(negedge clk);
        start_i = 1'b1;
        for (int i = 0; i < 30; i++) begin
            blen_i      = 2'(i % 3);
            itlv_i      = i[0];
            start_col_i = COL_W'(i * 13 + 5);
            rd_i        = 1'b1;
            lat_i       = LAT_W'(4 + (i % 2));
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (14) @(negedge clk);

        // R7: reserved length code
        tag = "R7";
        issue(3, 1'b0, 12, 1'b1, 4);
        issue(3, 1'b1, 7, 1'b0, 5);

        // R9: reserved latency codes on reads
        tag = "R9";
        issue(2, 1'b0, 3, 1'b1, 3);
        issue(1, 1'b1, 6, 1'b1, 6);
        issue(0, 1'b0, 1, 1'b1, 7);
        issue(2, 1'b1, 2, 1'b1, 0);
        issue(1, 1'b0, 9, 1'b1, 5);

        // R10: writes with any latency code
        tag = "R10";
        issue(2, 1'b1, 5, 1'b0, 7);
        issue(1, 1'b0, 2, 1'b0, 4);
        issue(0, 1'b1, 1, 1'b0, 2);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule